// File: doc/BRIEF.md
# TDM Link Rate-Mode Controller

This block sits beside a bank of serial TDM links and decides, from each link's static transmit and receive control words, how the links are combined. In normal operation every link runs on its own. A link can also ask for one of two merged, unframed modes. In the paired mode, two neighbouring links carry one faster stream. In the quad mode, four neighbouring links do so. In both cases one fixed link of the set keeps running and its partners are switched off. The block reports which links are live. It raises a high-impedance enable for every pin of a switched-off link and flags requests that are badly formed. It also checks that all links of a merged set carry the same inverse-multiplexing group number.

For every live merged link whose sync pin is set to drive, the block produces a one-clock transmit frame pulse. The period of that pulse depends on the merge mode. When the sync pin is an input, the link runs free and no pulse is made. Each link has its own small state machine with three states:

- `FP_QUIET`: no pulse.
- `FP_PAIR_RUN`: the counter wraps every `PAIR_PERIOD` clocks.
- `FP_QUAD_RUN`: the counter wraps every `QUAD_PERIOD` clocks.

At each clock the machine moves to the state that the link's decoded mode and sync direction call for. The transitions are:

- `QUIET->PAIR`, `QUIET->QUAD`, `PAIR->QUAD` and `QUAD->PAIR`: taken when the mode changes.
- `PAIR->QUIET` and `QUAD->QUIET`: taken when the mode drops or the sync pin turns to input.

Any change of state clears the period counter.

Top module: `tdm_rate_ctrl`

## Requirements
- R1: Control word field layout:
  - Bits 6:5 are the rate code: 10 requests the paired mode and 11 requests the quad mode.
  - Bits 4:3 are the multiplex field and bit 2 is the clock/sync format bit.
  - Receive word bit 10 is the cell-delineation bit.
  - A paired request on an even link 2p that is valid makes 2p live and link 2p+1 inactive.
- R2: A valid quad request on link 4q makes 4q live and links 4q+1, 4q+2 and 4q+3 inactive.
- R3: A request counts as valid only if all of the following hold:
  - both words have the multiplex field at 00 and the format bit at 0;
  - the receive word has bit 10 set;
  - the receive rate code equals the transmit rate code.
  An invalid request on a survivor link leaves the link live and normal, and raises cfg_err_o for that link.
- R4: A merged rate code on a link that cannot survive for that code raises cfg_err_o for that link and leaves it live and normal, unless the link is absorbed by another set. Such links are any odd link, and for code 11 any link not a multiple of four.
- R5: The control words of an absorbed partner link are ignored: they raise no error and do not change the set.
- R6: A valid quad on link 4q overrides a paired request on link 4q+2.
- R7: pin_hiz_o is set exactly for the inactive links. With all rate codes at 00, every link is live.
- R8: A live paired link with sync_out_i high pulses for one clock every PAIR_PERIOD (512) clocks. The first pulse falls in the PAIR_PERIOD-th cycle after the first clock edge that sees the mode.
- R9: A live quad link with sync_out_i high pulses for one clock every QUAD_PERIOD (1024) clocks, with the same first-pulse timing.
- R10: No pulse is made on a link that is normal, inactive, or has sync_out_i low.
- R11: A change of a link's merge mode restarts its period count from zero.
- R12: grp_err_o is raised on a live merged survivor when the group number of any member of its set differs from its own. It is never raised on a normal link.
- R13: While rst_n is low, no frame pulse is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_ctrl_i | input | N_LINKS*CW | Transmit control words, link i at bits i*CW +: CW |
| rx_ctrl_i | input | N_LINKS*CW | Receive control words, same packing |
| sync_out_i | input | N_LINKS | Per link: 1 when the sync pin drives, 0 when it is an input |
| ima_grp_i | input | N_LINKS*GW | Per-link group numbers |
| link_act_o | output | N_LINKS | Link is live |
| pin_hiz_o | output | N_LINKS | High-impedance enable for all pins of a link |
| frame_pulse_o | output | N_LINKS | One-clock transmit frame pulse |
| cfg_err_o | output | N_LINKS | Malformed merged-mode request on this link |
| grp_err_o | output | N_LINKS | Merged set with mixed group numbers |

## Verification
The assertions assume that the control words, sync directions and group numbers are quasi-static. They may change only between clock edges and must hold long enough for the decode to settle, since the decode is combinational and feeds the frame state machines directly. The stimulus meets this by changing every configuration input on the falling edge, as a complete set, and then leaving it untouched for more than one full quad period. The pulse scoreboard is filled from the requirement timing, counted from the edge that follows each change. Any pulse that has no matching entry, or any entry left unmatched, is a failure.

// File: rtl/tdm_rate_pkg.sv
package tdm_rate_pkg;
    typedef enum logic [1:0] {
        LM_NORMAL   = 2'd0,
        LM_PAIR     = 2'd1,
        LM_QUAD     = 2'd2,
        LM_ABSORBED = 2'd3
    } link_mode_e;

    typedef enum logic [1:0] {
        FP_QUIET    = 2'd0,
        FP_PAIR_RUN = 2'd1,
        FP_QUAD_RUN = 2'd2
    } fp_state_e;

    // control word field positions
    localparam int RATE_HI   = 6;
    localparam int RATE_LO   = 5;
    localparam int MUX_HI    = 4;
    localparam int MUX_LO    = 3;
    localparam int FMT_BIT   = 2;
    localparam int DELIN_BIT = 10;

    localparam logic [1:0] RATE_PAIR = 2'b10;
    localparam logic [1:0] RATE_QUAD = 2'b11;
endpackage

// File: rtl/tdm_rate_decode.sv
module tdm_rate_decode
    import tdm_rate_pkg::*;
#(
    parameter int N_LINKS = 16,
    parameter int CW      = 16
) (
    input  logic [N_LINKS*CW-1:0]     tx_ctrl_i,
    input  logic [N_LINKS*CW-1:0]     rx_ctrl_i,
    output link_mode_e [N_LINKS-1:0]  mode_o,
    output logic [N_LINKS-1:0]        cfg_err_o
);
    logic [N_LINKS-1:0] pair_ok;
    logic [N_LINKS-1:0] quad_ok;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_req
        logic [CW-1:0] tw;
        logic [CW-1:0] rw;
        logic          fields_ok;

        assign tw = tx_ctrl_i[g*CW +: CW];
        assign rw = rx_ctrl_i[g*CW +: CW];
        assign fields_ok = (tw[MUX_HI:MUX_LO] == 2'b00) && !tw[FMT_BIT]
                        && (rw[MUX_HI:MUX_LO] == 2'b00) && !rw[FMT_BIT]
                        && rw[DELIN_BIT]
                        && (rw[RATE_HI:RATE_LO] == tw[RATE_HI:RATE_LO]);

        if (g % 4 == 0) begin : g_qsurv
            assign quad_ok[g] = (tw[RATE_HI:RATE_LO] == RATE_QUAD) && fields_ok;
        end else begin : g_qnone
            assign quad_ok[g] = 1'b0;
        end

        if (g % 2 == 0) begin : g_psurv
            assign pair_ok[g] = (tw[RATE_HI:RATE_LO] == RATE_PAIR) && fields_ok;
        end else begin : g_pnone
            assign pair_ok[g] = 1'b0;
        end
    end

    for (genvar g = 0; g < N_LINKS; g++) begin : g_mode
        localparam int  QS      = g - (g % 4);
        localparam int  PS      = g - (g % 2);
        localparam bit  IS_QSRV = (g == QS);
        localparam bit  IS_PSRV = (g == PS);
        link_mode_e m;

        always_comb begin
            if (quad_ok[QS] && !IS_QSRV)      m = LM_ABSORBED;
            else if (quad_ok[g])              m = LM_QUAD;
            else if (pair_ok[PS] && !IS_PSRV) m = LM_ABSORBED;
            else if (pair_ok[g])              m = LM_PAIR;
            else                              m = LM_NORMAL;
        end

        assign mode_o[g]    = m;
        assign cfg_err_o[g] = (m == LM_NORMAL) && tx_ctrl_i[g*CW + RATE_HI];
    end
endmodule

// File: rtl/tdm_grp_check.sv
module tdm_grp_check
    import tdm_rate_pkg::*;
#(
    parameter int N_LINKS = 16,
    parameter int GW      = 4
) (
    input  logic [N_LINKS*GW-1:0]     ima_grp_i,
    input  link_mode_e [N_LINKS-1:0]  mode_i,
    output logic [N_LINKS-1:0]        grp_err_o
);
    for (genvar g = 0; g < N_LINKS; g++) begin : g_set
        logic p_mis;
        logic q_mis;

        if ((g % 2 == 0) && (g + 1 < N_LINKS)) begin : g_pair
            assign p_mis = ima_grp_i[(g+1)*GW +: GW] != ima_grp_i[g*GW +: GW];
        end else begin : g_nopair
            assign p_mis = 1'b0;
        end

        if ((g % 4 == 0) && (g + 3 < N_LINKS)) begin : g_quad
            assign q_mis = (ima_grp_i[(g+1)*GW +: GW] != ima_grp_i[g*GW +: GW])
                        || (ima_grp_i[(g+2)*GW +: GW] != ima_grp_i[g*GW +: GW])
                        || (ima_grp_i[(g+3)*GW +: GW] != ima_grp_i[g*GW +: GW]);
        end else begin : g_noquad
            assign q_mis = 1'b0;
        end

        assign grp_err_o[g] = ((mode_i[g] == LM_PAIR) && p_mis)
                           || ((mode_i[g] == LM_QUAD) && q_mis);
    end
endmodule

// File: rtl/tdm_frame_pulse.sv
module tdm_frame_pulse
    import tdm_rate_pkg::*;
#(
    parameter int PAIR_PERIOD = 512,
    parameter int QUAD_PERIOD = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  link_mode_e mode_i,
    input  logic       sync_out_i,
    output logic       pulse_o
);
    localparam int MAXP  = (QUAD_PERIOD > PAIR_PERIOD) ? QUAD_PERIOD : PAIR_PERIOD;
    localparam int CNT_W = $clog2(MAXP);
    localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(PAIR_PERIOD - 1);
    localparam logic [CNT_W-1:0] QUAD_LAST = CNT_W'(QUAD_PERIOD - 1);

    fp_state_e        state_q;
    fp_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // next state from decoded mode and sync direction
    always_comb begin
        state_d = FP_QUIET;
        if (sync_out_i) begin
            if (mode_i == LM_PAIR)      state_d = FP_PAIR_RUN;
            else if (mode_i == LM_QUAD) state_d = FP_QUAD_RUN;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FP_QUIET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FP_QUIET:    wrap = 1'b0;
            FP_PAIR_RUN: wrap = (cnt_q == PAIR_LAST);
            FP_QUAD_RUN: wrap = (cnt_q == QUAD_LAST);
            default:     wrap = 1'b0;
        endcase
        pulse_o = wrap;
    end

    // period counter, cleared on any state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if ((state_d != state_q) || wrap || (state_q == FP_QUIET))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tdm_rate_ctrl.sv
module tdm_rate_ctrl
    import tdm_rate_pkg::*;
#(
    parameter int N_LINKS     = 16,
    parameter int CW          = 16,
    parameter int GW          = 4,
    parameter int PAIR_PERIOD = 512,
    parameter int QUAD_PERIOD = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_LINKS*CW-1:0] tx_ctrl_i,
    input  logic [N_LINKS*CW-1:0] rx_ctrl_i,
    input  logic [N_LINKS-1:0]    sync_out_i,
    input  logic [N_LINKS*GW-1:0] ima_grp_i,
    output logic [N_LINKS-1:0]    link_act_o,
    output logic [N_LINKS-1:0]    pin_hiz_o,
    output logic [N_LINKS-1:0]    frame_pulse_o,
    output logic [N_LINKS-1:0]    cfg_err_o,
    output logic [N_LINKS-1:0]    grp_err_o
);
    link_mode_e [N_LINKS-1:0] mode;

    tdm_rate_decode #(.N_LINKS(N_LINKS), .CW(CW)) u_decode (
        .tx_ctrl_i (tx_ctrl_i),
        .rx_ctrl_i (rx_ctrl_i),
        .mode_o    (mode),
        .cfg_err_o (cfg_err_o)
    );

    tdm_grp_check #(.N_LINKS(N_LINKS), .GW(GW)) u_grp (
        .ima_grp_i (ima_grp_i),
        .mode_i    (mode),
        .grp_err_o (grp_err_o)
    );

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        assign link_act_o[g] = (mode[g] != LM_ABSORBED);
        assign pin_hiz_o[g]  = (mode[g] == LM_ABSORBED);

        tdm_frame_pulse #(.PAIR_PERIOD(PAIR_PERIOD), .QUAD_PERIOD(QUAD_PERIOD)) u_fp (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode[g]),
            .sync_out_i (sync_out_i[g]),
            .pulse_o    (frame_pulse_o[g])
        );
    end
endmodule

// File: rtl/tdm_rate_ctrl_chk.sv
module tdm_rate_ctrl_chk
    import tdm_rate_pkg::*;
#(
    parameter int N_LINKS = 16,
    parameter int CW      = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_LINKS*CW-1:0] tx_ctrl_i,
    input logic [N_LINKS-1:0]    link_act_o,
    input logic [N_LINKS-1:0]    pin_hiz_o,
    input logic [N_LINKS-1:0]    frame_pulse_o,
    input logic [N_LINKS-1:0]    cfg_err_o,
    input logic [N_LINKS-1:0]    grp_err_o
);
    AST_PULSE_NOT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse_o & pin_hiz_o) == '0); // R7

    for (genvar g = 0; g < N_LINKS; g++) begin : g_chk
        AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
            frame_pulse_o[g] |=> !frame_pulse_o[g]); // R8

        AST_ERR_STAYS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err_o[g] |-> (link_act_o[g] && !frame_pulse_o[g])); // R3

        if (g % 2 == 1) begin : g_odd
            AST_ODD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                !frame_pulse_o[g]); // R10
        end else if (g + 1 < N_LINKS) begin : g_even
            AST_GRP_ONLY_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
                grp_err_o[g] |-> pin_hiz_o[g+1]); // R12
        end

        if ((g % 4 == 0) && (g + 3 < N_LINKS)) begin : g_quad
            AST_QUAD_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
                ((tx_ctrl_i[g*CW + RATE_LO +: 2] == RATE_QUAD) && !cfg_err_o[g])
                |-> (link_act_o[g] && (pin_hiz_o[g+3 -: 3] == 3'b111))); // R2
        end
    end
endmodule

bind tdm_rate_ctrl tdm_rate_ctrl_chk #(.N_LINKS(N_LINKS), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_ctrl_i     (tx_ctrl_i),
    .link_act_o    (link_act_o),
    .pin_hiz_o     (pin_hiz_o),
    .frame_pulse_o (frame_pulse_o),
    .cfg_err_o     (cfg_err_o),
    .grp_err_o     (grp_err_o)
);

// File: tb/tdm_rate_ctrl_tb.sv
`timescale 1ns/1ps
module tdm_rate_ctrl_tb;
    localparam int N  = 16;
    localparam int CW = 16;
    localparam int GW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N*CW-1:0] tx_ctrl;
    logic [N*CW-1:0] rx_ctrl;
    logic [N-1:0]    sync_out;
    logic [N*GW-1:0] ima_grp;
    logic [N-1:0]    link_act, pin_hiz, frame_pulse, cfg_err, grp_err;

    always #2.5 clk = ~clk;

    tdm_rate_ctrl #(.N_LINKS(N), .CW(CW), .GW(GW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_ctrl_i     (tx_ctrl),
        .rx_ctrl_i     (rx_ctrl),
        .sync_out_i    (sync_out),
        .ima_grp_i     (ima_grp),
        .link_act_o    (link_act),
        .pin_hiz_o     (pin_hiz),
        .frame_pulse_o (frame_pulse),
        .cfg_err_o     (cfg_err),
        .grp_err_o     (grp_err)
    );

    typedef struct {
        int    link;
        int    cyc;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: push the expected pulse train into the scoreboard
    task automatic push_train(int link, int first, int period, int upto, string req);
        for (int t = first; t <= upto; t += period) begin
            exp_t e;
            e.link = link;
            e.cyc  = t;
            e.req  = req;
            sbq.push_back(e);
        end
    endtask

    task automatic drain();
        n_chk++;
        if (sbq.size() != 0) begin
            n_fail++;
            foreach (sbq[k])
                $display("FAIL %s missing pulse link %0d cycle %0d: actual 0 expected 1",
                         sbq[k].req, sbq[k].link, sbq[k].cyc);
            sbq.delete();
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic set_link(int i, logic [15:0] tw, logic [15:0] rw);
        tx_ctrl[i*CW +: CW] = tw;
        rx_ctrl[i*CW +: CW] = rw;
    endtask

    // monitor: every observed pulse must match a scoreboard entry
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            for (int i = 0; i < N; i++) begin
                if (frame_pulse[i]) begin
                    int found;
                    found = -1;
                    foreach (sbq[k]) if (sbq[k].link == i && sbq[k].cyc == cyc) found = k;
                    n_chk++;
                    if (found < 0) begin
                        n_fail++;
                        $display("FAIL R10 unexpected pulse link %0d cycle %0d: actual 1 expected 0", i, cyc);
                    end else begin
                        sbq.delete(found);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c;
        int c2;
        int c3;
        rst_n    = 1'b0;
        tx_ctrl  = '0;
        rx_ctrl  = '0;
        sync_out = '0;
        ima_grp  = '0;
        repeat (4) @(negedge clk);
        check16("R13", "pulse in reset", frame_pulse, 16'h0000);
        check16("R7", "all live normal", link_act, 16'hFFFF);
        check16("R7", "no hiz normal", pin_hiz, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // phase A: mixed configuration
        set_link(0,  16'h0040, 16'h0440); // R1 valid pair
        set_link(1,  16'h007C, 16'h0000); // R5 junk on absorbed partner
        set_link(4,  16'h0060, 16'h0460); // R2 valid quad
        set_link(6,  16'h0040, 16'h0440); // R6 pair under quad
        set_link(8,  16'h0040, 16'h0040); // R3 missing delineation bit
        set_link(10, 16'h0060, 16'h0460); // R4 quad code on non-survivor
        set_link(11, 16'h0040, 16'h0440); // R4 pair code on odd link
        set_link(12, 16'h0060, 16'h0460); // quad with sync input
        sync_out = 16'hEFFF;
        ima_grp[13*GW +: GW] = 4'd5;      // R12 mismatch in quad 12
        ima_grp[9*GW +: GW]  = 4'd3;      // R12 ignored on normal link 8
        c = cyc;
        #1;
        check16("R1", "live links A", link_act, 16'h1F1D);
        check16("R7", "hiz links A", pin_hiz, 16'hE0E2);
        check16("R3", "cfg errors A", cfg_err, 16'h0D00);
        check16("R12", "group errors A", grp_err, 16'h1000);
        push_train(0, c + 512, 512, c + 2300, "R8");
        push_train(4, c + 1024, 1024, c + 2300, "R9");
        wait_until(c + 2300);
        drain();

        // phase B: link 0 moves to quad mid-period
        set_link(0, 16'h0060, 16'h0460);
        set_link(8, 16'h0044, 16'h0440);  // R3 format bit set
        c2 = cyc;
        #1;
        check16("R2", "live links B", link_act, 16'h1F11);
        check16("R3", "cfg errors B", cfg_err, 16'h0D00);
        check16("R12", "group errors B", grp_err, 16'h1000);
        push_train(0, c2 + 1024, 1024, c2 + 2200, "R11");
        push_train(4, c + 3072, 1024, c2 + 2200, "R9");
        wait_until(c2 + 2200);
        drain();

        // phase C: sync pins become inputs, links run free
        sync_out = 16'h0000;
        c3 = cyc;
        wait_until(c3 + 1100);
        drain();
        check16("R10", "no pulse free-run", frame_pulse, 16'h0000);

        // phase D: back to all normal
        for (int i = 0; i < N; i++) set_link(i, 16'h0000, 16'h0000);
        #1;
        check16("R7", "all live again", link_act, 16'hFFFF);
        check16("R4", "no errors normal", cfg_err, 16'h0000);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule